// File: doc/BRIEF.md
# USB Device Control Register and Token Qualifier

This block holds the device-level control word of a full-speed USB device controller. It also uses that word to decide how each token from the packet engine is treated. Software writes and reads the word through a single-register port. The word carries:

- the function address the device answers to;
- an enable;
- a latched "SETUP seen" flag;
- a bit that keeps the clock request high;
- a bit that allows LPM tokens;
- four per-class options that control whether NAKed transfers raise interrupts.

The packet engine reports three kinds of event. A token event gives the kind (SETUP, IN, OUT or LPM) and the target address. A handshake event gives the endpoint class, the direction and the ACK or NAK outcome. A separate pulse marks a SETUP that was acknowledged. From these events the block drives several outputs:

- an address-match signal;
- a force-NAK signal while a SETUP is pending;
- a no-handshake signal for LPM tokens the device does not support;
- four one-cycle interrupt pulses, one per endpoint class;
- the clock request towards the clock controller.

Top module: `usbdev_cmdstat`

## Requirements
- R1: After reset the register reads 0x00000800. Only the LPM-allowed bit (bit 11) is set.
- R2: A write loads the address (bits 6:0), enable (bit 7), keep-clock (bit 9), LPM-allowed (bit 11) and the interrupt-on-NAK options (bits 15:12). Reads return these fields at the same positions. Bit 10 and bits 31:16 always read 0, and writes to them are ignored.
- R3: A bus-reset pulse clears the address field to 0 on the next clock edge. All other fields keep their values.
- R4: `respond` is 1 in the cycle of a token event only when enable is 1 and the token address equals the address field.
- R5: A `setup_ack` pulse sets the SETUP flag (bit 8). A write with bit 8 at 1 clears the flag. A write with bit 8 at 0 leaves the flag unchanged.
- R6: When `setup_ack` and a clearing write fall in the same cycle, the flag ends up set.
- R7: While the SETUP flag is 1, `force_nak` is 1 for every responded IN (kind 1) or OUT (kind 2) token. It stays 0 for SETUP (kind 0) and LPM (kind 3) tokens, and stays 0 whenever the flag is 0.
- R8: `lpm_no_hs` is 1 for a responded LPM token (kind 3) when LPM-allowed is 0. It is 0 when LPM-allowed is 1.
- R9: A handshake event raises a one-cycle pulse on its class output in the same cycle. The options are bit 12 for bulk OUT, bit 13 for bulk IN, bit 14 for control OUT and bit 15 for control IN. An ACK always raises the pulse. A NAK raises it only when the class option is 1.
- R10: `clk_req` equals `clk_need` when keep-clock is 0. It is held at 1 when keep-clock is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_reset | input | 1 | USB bus reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| setup_ack | input | 1 | SETUP token received and acknowledged |
| tok_valid | input | 1 | Token event valid |
| tok_kind | input | 2 | 0 SETUP, 1 IN, 2 OUT, 3 LPM |
| tok_addr | input | 7 | Token function address |
| xfer_done | input | 1 | Handshake outcome valid |
| xfer_dir_in | input | 1 | 1 IN endpoint, 0 OUT endpoint |
| xfer_ctrl | input | 1 | 1 control endpoint, 0 bulk/interrupt |
| xfer_nak | input | 1 | 1 NAK, 0 ACK |
| clk_need | input | 1 | Functional clock-need request |
| respond | output | 1 | Token addressed to this enabled device |
| force_nak | output | 1 | Answer this token with NAK |
| lpm_no_hs | output | 1 | Send no handshake for this LPM token |
| irq_bulk_out | output | 1 | Bulk/interrupt OUT transfer interrupt |
| irq_bulk_in | output | 1 | Bulk/interrupt IN transfer interrupt |
| irq_ctrl_out | output | 1 | Control OUT transfer interrupt |
| irq_ctrl_in | output | 1 | Control IN transfer interrupt |
| clk_req | output | 1 | Clock request |

## Verification
The token path is driven with a matching address, a neighbouring address, and the device disabled. This separates the address compare from the enable gate. All four token kinds are sent with the SETUP flag both set and clear, which shows that only data tokens are forced to NAK.

Handshake events mix ACK and NAK across the four classes while only two options are set. A wrong class-to-option mapping therefore shows up as a missing or extra pulse. The flag is also given a zero write, a clearing write, and a clearing write that collides with a new SETUP, which separates clear-only from set-wins behaviour.

// File: rtl/usbdev_cmdstat_pkg.sv
package usbdev_cmdstat_pkg;

  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 32;
  localparam int N_CLASS = 4;
  localparam int CLS_W   = $clog2(N_CLASS);

  localparam int B_EN      = 7;
  localparam int B_SETUP   = 8;
  localparam int B_CLKKEEP = 9;
  localparam int B_RSVD    = 10;
  localparam int B_LPM     = 11;
  localparam int B_OPT     = 12;

  typedef enum logic [1:0] {
    TOK_SETUP = 2'd0,
    TOK_IN    = 2'd1,
    TOK_OUT   = 2'd2,
    TOK_LPM   = 2'd3
  } tok_kind_e;

  typedef struct packed {
    logic [N_CLASS-1:0] nak_irq;
    logic               lpm_ok;
    logic               clk_keep;
    logic               setup;
    logic               en;
    logic [ADDR_W-1:0]  addr;
  } csr_t;

  // class index: bulk OUT 0, bulk IN 1, control OUT 2, control IN 3
  function automatic logic [CLS_W-1:0] class_idx(input logic ctrl, input logic dir_in);
    return {ctrl, dir_in};
  endfunction

  function automatic logic irq_qual(input logic done, input logic nak, input logic opt);
    return done & (~nak | opt);
  endfunction

endpackage

// File: rtl/usbdev_csr_reg.sv
module usbdev_csr_reg
  import usbdev_cmdstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              setup_ack,
  output csr_t              csr,
  output logic [DATA_W-1:0] rdata
);

  logic setup_clr;
  logic setup_next;

  assign setup_clr  = reg_wr & reg_wdata[B_SETUP];
  assign setup_next = setup_ack | (csr.setup & ~setup_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr        <= '0;
      csr.lpm_ok <= 1'b1;
    end else begin
      if (reg_wr) begin
        csr.addr     <= reg_wdata[ADDR_W-1:0];
        csr.en       <= reg_wdata[B_EN];
        csr.clk_keep <= reg_wdata[B_CLKKEEP];
        csr.lpm_ok   <= reg_wdata[B_LPM];
        csr.nak_irq  <= reg_wdata[B_OPT +: N_CLASS];
      end
      if (bus_reset) csr.addr <= '0;
      csr.setup <= setup_next;
    end
  end

  always_comb begin
    rdata                    = '0;
    rdata[ADDR_W-1:0]        = csr.addr;
    rdata[B_EN]              = csr.en;
    rdata[B_SETUP]           = csr.setup;
    rdata[B_CLKKEEP]         = csr.clk_keep;
    rdata[B_LPM]             = csr.lpm_ok;
    rdata[B_OPT +: N_CLASS]  = csr.nak_irq;
  end

  p_setup_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    setup_ack |=> rdata[B_SETUP]);
  p_setup_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_ack && !setup_clr) |=> rdata[B_SETUP] == $past(rdata[B_SETUP]));
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_ack && setup_clr) |=> rdata[B_SETUP]);
  p_bus_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> rdata[ADDR_W-1:0] == '0);
  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_wdata[DATA_W-1:16] != '0 || reg_wdata[B_RSVD]))
      |=> (rdata[DATA_W-1:16] == '0 && !rdata[B_RSVD]));

endmodule

// File: rtl/usbdev_token_ctl.sv
module usbdev_token_ctl
  import usbdev_cmdstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  csr_t              csr,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic              xfer_done,
  input  logic              xfer_dir_in,
  input  logic              xfer_ctrl,
  input  logic              xfer_nak,
  output logic              respond,
  output logic              force_nak,
  output logic              lpm_no_hs,
  output logic [N_CLASS-1:0] irq
);

  logic             addr_hit;
  logic             is_data_tok;
  logic [CLS_W-1:0] cls;

  assign addr_hit    = (tok_addr == csr.addr);
  assign respond     = tok_valid & csr.en & addr_hit;
  assign is_data_tok = (tok_kind == TOK_IN) | (tok_kind == TOK_OUT);
  assign force_nak   = respond & csr.setup & is_data_tok;
  assign lpm_no_hs   = respond & (tok_kind == TOK_LPM) & ~csr.lpm_ok;
  assign cls         = class_idx(xfer_ctrl, xfer_dir_in);

  for (genvar i = 0; i < N_CLASS; i++) begin : g_irq
    assign irq[i] = irq_qual(xfer_done && (cls == CLS_W'(i)), xfer_nak, csr.nak_irq[i]);
  end

  p_respond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    respond |-> (tok_valid && csr.en));
  p_force_nak_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_nak |-> (respond && csr.setup && tok_kind != TOK_LPM));
  p_lpm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lpm_no_hs |-> (!csr.lpm_ok && tok_kind == TOK_LPM));
  p_irq_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq) && (irq != '0 -> xfer_done));
  p_irq_nak_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && xfer_nak && !csr.nak_irq[cls]) |-> irq == '0);

endmodule

// File: rtl/usbdev_cmdstat.sv
module usbdev_cmdstat
  import usbdev_cmdstat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_reset,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        setup_ack,
  input  logic        tok_valid,
  input  logic [1:0]  tok_kind,
  input  logic [6:0]  tok_addr,
  input  logic        xfer_done,
  input  logic        xfer_dir_in,
  input  logic        xfer_ctrl,
  input  logic        xfer_nak,
  input  logic        clk_need,
  output logic        respond,
  output logic        force_nak,
  output logic        lpm_no_hs,
  output logic        irq_bulk_out,
  output logic        irq_bulk_in,
  output logic        irq_ctrl_out,
  output logic        irq_ctrl_in,
  output logic        clk_req
);

  csr_t               csr;
  logic [N_CLASS-1:0] irq;

  usbdev_csr_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .setup_ack (setup_ack),
    .csr       (csr),
    .rdata     (reg_rdata)
  );

  usbdev_token_ctl u_tok (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr         (csr),
    .tok_valid   (tok_valid),
    .tok_kind    (tok_kind),
    .tok_addr    (tok_addr),
    .xfer_done   (xfer_done),
    .xfer_dir_in (xfer_dir_in),
    .xfer_ctrl   (xfer_ctrl),
    .xfer_nak    (xfer_nak),
    .respond     (respond),
    .force_nak   (force_nak),
    .lpm_no_hs   (lpm_no_hs),
    .irq         (irq)
  );

  assign irq_bulk_out = irq[0];
  assign irq_bulk_in  = irq[1];
  assign irq_ctrl_out = irq[2];
  assign irq_ctrl_in  = irq[3];
  assign clk_req      = csr.clk_keep | clk_need;

  p_clk_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[B_CLKKEEP] |-> clk_req);
  p_clk_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[B_CLKKEEP] |-> (clk_req == clk_need));

endmodule

// File: tb/usbdev_cmdstat_tb.sv
module usbdev_cmdstat_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0, reg_wr = 1'b0, setup_ack = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        tok_valid = 1'b0;
  logic [1:0]  tok_kind = '0;
  logic [6:0]  tok_addr = '0;
  logic        xfer_done = 1'b0, xfer_dir_in = 1'b0, xfer_ctrl = 1'b0, xfer_nak = 1'b0;
  logic        clk_need = 1'b0;
  logic [31:0] reg_rdata;
  logic        respond, force_nak, lpm_no_hs;
  logic        irq_bulk_out, irq_bulk_in, irq_ctrl_out, irq_ctrl_in, clk_req;

  always #10 clk = ~clk;

  usbdev_cmdstat u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .setup_ack(setup_ack),
    .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_addr(tok_addr),
    .xfer_done(xfer_done), .xfer_dir_in(xfer_dir_in), .xfer_ctrl(xfer_ctrl),
    .xfer_nak(xfer_nak), .clk_need(clk_need), .respond(respond),
    .force_nak(force_nak), .lpm_no_hs(lpm_no_hs), .irq_bulk_out(irq_bulk_out),
    .irq_bulk_in(irq_bulk_in), .irq_ctrl_out(irq_ctrl_out),
    .irq_ctrl_in(irq_ctrl_in), .clk_req(clk_req)
  );

  // observed bundle: rdata[39:8], respond 7, force_nak 6, lpm_no_hs 5,
  // irq ctrl_in 4, ctrl_out 3, bulk_in 2, bulk_out 1, clk_req 0
  logic [39:0] obs;
  assign obs = {reg_rdata, respond, force_nak, lpm_no_hs, irq_ctrl_in,
                irq_ctrl_out, irq_bulk_in, irq_bulk_out, clk_req};

  typedef struct {
    string       req;
    logic [39:0] mask;
    logic [39:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    reg_wr = 0; setup_ack = 0; bus_reset = 0; tok_valid = 0; xfer_done = 0;
  endtask

  task automatic exp_reg(string req, logic [31:0] v);
    q.push_back('{req, {32'hFFFF_FFFF, 8'h00}, {v, 8'h00}});
  endtask

  task automatic exp_out(string req, logic [7:0] m, logic [7:0] v);
    q.push_back('{req, {32'h0, m}, {32'h0, v}});
  endtask

  task automatic wr(logic [31:0] d);
    tick(); idle(); reg_wr = 1; reg_wdata = d;
    tick(); idle();
  endtask

  task automatic tok(logic [1:0] k, logic [6:0] a);
    tick(); idle(); tok_valid = 1; tok_kind = k; tok_addr = a;
  endtask

  task automatic xfer(logic c, logic d, logic n);
    tick(); idle(); xfer_done = 1; xfer_ctrl = c; xfer_dir_in = d; xfer_nak = n;
  endtask

  // monitor: compares queued expectations after inputs settle
  always begin
    @(negedge clk);
    #2;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ((obs & it.mask) !== (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s: actual %h expected %h (mask %h)",
                 it.req, obs & it.mask, it.exp & it.mask, it.mask);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    tick(); rst_n = 1;
    tick();
    exp_reg("R1", 32'h0000_0800);
    exp_out("R10", 8'h01, 8'h00);

    // R2: all ones, reserved ignored, SETUP write-one does nothing when clear
    wr(32'hFFFF_FFFF);
    exp_reg("R2", 32'h0000_FAFF);
    wr(32'h0000_0085);
    exp_reg("R2", 32'h0000_0085);

    // R4: address compare and enable
    tok(2'd1, 7'd5); exp_out("R4", 8'h80, 8'h80);
    tok(2'd1, 7'd6); exp_out("R4", 8'h80, 8'h00);
    wr(32'h0000_0005);
    tok(2'd1, 7'd5); exp_out("R4", 8'h80, 8'h00);
    wr(32'h0000_0085);
    tok(2'd2, 7'd5); exp_out("R7", 8'h40, 8'h00);

    // R5: setup set
    tick(); idle(); setup_ack = 1;
    tick(); idle();
    exp_reg("R5", 32'h0000_0185);
    tok(2'd1, 7'd5); exp_out("R7", 8'hC0, 8'hC0);
    tok(2'd2, 7'd5); exp_out("R7", 8'hC0, 8'hC0);
    tok(2'd0, 7'd5); exp_out("R7", 8'hC0, 8'h80);
    tok(2'd3, 7'd5); exp_out("R7", 8'h40, 8'h00);
    tok(2'd1, 7'd9); exp_out("R7", 8'hC0, 8'h00);
    wr(32'h0000_0085);
    exp_reg("R5", 32'h0000_0185);
    tick(); idle(); reg_wr = 1; reg_wdata = 32'h0000_0185; setup_ack = 1;
    tick(); idle();
    exp_reg("R6", 32'h0000_0185);
    wr(32'h0000_0185);
    exp_reg("R5", 32'h0000_0085);
    tok(2'd1, 7'd5); exp_out("R7", 8'hC0, 8'h80);

    // R8: LPM handling
    tok(2'd3, 7'd5); exp_out("R8", 8'h20, 8'h20);
    wr(32'h0000_5885);
    tok(2'd3, 7'd5); exp_out("R8", 8'h20, 8'h00);

    // R9: options bulk OUT and control OUT set
    xfer(0, 0, 0); exp_out("R9", 8'h1E, 8'h02);
    xfer(0, 1, 1); exp_out("R9", 8'h1E, 8'h00);
    xfer(0, 1, 0); exp_out("R9", 8'h1E, 8'h04);
    xfer(0, 0, 1); exp_out("R9", 8'h1E, 8'h02);
    xfer(1, 1, 1); exp_out("R9", 8'h1E, 8'h00);
    xfer(1, 0, 1); exp_out("R9", 8'h1E, 8'h08);
    xfer(1, 1, 0); exp_out("R9", 8'h1E, 8'h10);
    tick(); idle(); exp_out("R9", 8'h1E, 8'h00);

    // R3: bus reset
    tick(); idle(); bus_reset = 1;
    tick(); idle();
    exp_reg("R3", 32'h0000_5880);

    // R10: clock request
    tick(); clk_need = 1; exp_out("R10", 8'h01, 8'h01);
    tick(); clk_need = 0; exp_out("R10", 8'h01, 8'h00);
    wr(32'h0000_5A80);
    exp_out("R10", 8'h01, 8'h01);

    tick(); tick();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule